// File: doc/BRIEF.md
# Selectable-Clock Watchdog Timer

This block watches for software that has stopped making progress. It counts ticks from one of three clock-enable sources: a free-running internal oscillator, the instruction clock (system clock divided by four), or a real-time-clock oscillator. If software does not issue a clear strobe often enough, the block emits a one-cycle time-out pulse. Reset generation logic elsewhere acts on that pulse.

The count chain has two parts. A low prescaler of `PRE_W` bits runs freely. An upper stage of `STG_W` bits sits above it. A software clear zeroes only the upper stage, so the number of ticks from a clear to the time-out depends on where the prescaler was. With the defaults (15 + 1 bits), a time-out comes between 2^15 and 2^16 source ticks after a clear.

A configuration input switches the whole function off. A halt input freezes counting only when the instruction clock is the selected source, because that clock stops in halt. The other two sources keep the watchdog counting through halt.

Top module: `sel_clk_watchdog`

## Requirements
- R1: After a synchronous active-low reset, `timeout_o` is low and the whole chain is zero, so the first time-out follows exactly 2^(PRE_W+STG_W) selected ticks.
- R2: `src_sel_i` picks the counting source: 2'b00 internal oscillator tick, 2'b01 instruction-clock tick, 2'b10 real-time-clock tick, 2'b11 no source (nothing counts). Ticks on unselected inputs have no effect.
- R3: A clear (`sw_clr_i`) zeroes the upper stage and leaves the prescaler unchanged. The next time-out therefore follows between 2^PRE_W·(2^STG_W−1)+1 and 2^(PRE_W+STG_W) ticks, and the exact count is 2^(PRE_W+STG_W) minus the prescaler value at the clear.
- R4: `timeout_o` is high for exactly one cycle: the cycle after the clock edge that samples the final tick. The chain is then all zero, so the next time-out follows 2^(PRE_W+STG_W) more ticks.
- R5: While `wdt_off_i` is high, no tick advances the chain, no time-out occurs and `sw_clr_i` is ignored. The count held before the disable resumes when the disable is removed.
- R6: While `halt_i` is high and the instruction clock is selected, instruction ticks do not advance the chain. The held count resumes when halt is released.
- R7: `halt_i` has no effect when the internal oscillator or the real-time clock is selected.
- R8: Any change of `src_sel_i` zeroes the whole chain. A tick that arrives in the cycle of the change is not counted.
- R9: When a clear coincides with the final tick, no time-out occurs. That tick still advances the prescaler, which wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick_i | input | 1 | Internal oscillator tick, one-cycle enable |
| instr_tick_i | input | 1 | Instruction-clock tick, one-cycle enable |
| rtc_tick_i | input | 1 | Real-time-clock tick, one-cycle enable |
| src_sel_i | input | 2 | Count source select |
| wdt_off_i | input | 1 | Disable option |
| sw_clr_i | input | 1 | Software clear strobe |
| halt_i | input | 1 | Core halted indication |
| timeout_o | output | 1 | One-cycle time-out pulse |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as the tick that would end the window. The stimulus gets there by counting ticks exactly from reset and raising the clear together with the last one. A second hard case is proving that a clear leaves the prescaler alone. For this, the bench parks the prescaler at its top value, clears, and checks that the time-out arrives after the short end of the window rather than the long end. The bench uses a 4-bit prescaler, so each window is a few dozen ticks.

// File: rtl/wdog_pkg.sv
// Shared types for the selectable-clock watchdog.
// Assumes: the two-bit source code is decoded only through this enum.
package wdog_pkg;
    typedef enum logic [1:0] {
        SRC_OSC   = 2'b00,
        SRC_INSTR = 2'b01,
        SRC_RTC   = 2'b10,
        SRC_NONE  = 2'b11
    } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
// Source selector: turns the selected tick into a single advance enable,
// applies the disable option and the halt freeze, and qualifies the clear.
// Assumes: ticks are one-cycle enables synchronous to clk.
module wdog_tick_sel
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      osc_tick,
    input  logic      instr_tick,
    input  logic      rtc_tick,
    input  wdog_src_e src,
    input  logic      off,
    input  logic      halt,
    input  logic      clr_req,
    output logic      adv,
    output logic      clr
);
    logic picked;
    logic frozen;

    // Pick the tick belonging to the selected source.
    always_comb begin
        case (src)
            SRC_OSC:   picked = osc_tick;
            SRC_INSTR: picked = instr_tick;
            SRC_RTC:   picked = rtc_tick;
            default:   picked = 1'b0;
        endcase
    end

    // Instruction clock stops in halt; the other sources run on.
    assign frozen = halt && (src == SRC_INSTR);

    // Advance only when enabled and not frozen.
    assign adv = picked && !off && !frozen;

    // Clear is a no-operation while the watchdog is disabled.
    assign clr = clr_req && !off;

    // R5: disabled watchdog never advances or clears
    a_r5_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> (!adv && !clr));
    // R6: halt with instruction clock never advances
    a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && src == SRC_INSTR) |-> !adv);
    // R2: code with no source never advances
    a_r2_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |-> !adv);
endmodule

// File: rtl/wdog_prescaler.sv
// Free-running low prescaler of the chain. Only reset or a source change
// zero it; the software clear does not touch it.
// Assumes: adv is a one-cycle enable.
module wdog_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic adv,
    output logic carry
);
    logic [PRE_W-1:0] cnt;

    // Count qualified ticks; zero on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    // Carry out when a tick arrives at the top value.
    assign carry = adv && (&cnt);

    // R8: a flush leaves the prescaler at zero
    a_r8_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));
endmodule

// File: rtl/wdog_stage.sv
// Upper stage of the chain and time-out register. Counts prescaler
// carries; raises a one-cycle pulse when a carry meets a full stage.
// Assumes: clr has already been qualified by the disable option.
module wdog_stage #(
    parameter int STG_W = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic clr,
    input  logic carry,
    output logic timeout
);
    logic [STG_W-1:0] stg;
    logic             last;

    // Final carry of the chain.
    assign last = carry && (&stg);

    // Stage count and time-out pulse; the clear wins over a final carry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            stg     <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= last && !clr;
            if (clr)
                stg <= '0;
            else if (carry)
                stg <= stg + 1'b1;
        end
    end

    // R9: a clear suppresses the time-out in the following cycle
    a_r9_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !timeout);
    // R3: after a clear the stage restarts from zero
    a_r3_clr_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !flush) |=> (stg == '0));
endmodule

// File: rtl/sel_clk_watchdog.sv
// Watchdog timer with a selectable count source. Chains the source
// selector, the free-running prescaler and the upper stage; flushes the
// chain when the source select changes.
// Assumes: all tick inputs are single-cycle enables in the clk domain.
module sel_clk_watchdog
    import wdog_pkg::*;
#(
    parameter int PRE_W = 15,
    parameter int STG_W = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick_i,
    input  logic       instr_tick_i,
    input  logic       rtc_tick_i,
    input  logic [1:0] src_sel_i,
    input  logic       wdt_off_i,
    input  logic       sw_clr_i,
    input  logic       halt_i,
    output logic       timeout_o
);
    wdog_src_e src;
    logic [1:0] sel_q;
    logic       flush;
    logic       adv;
    logic       clr;
    logic       carry;

    assign src = wdog_src_e'(src_sel_i);

    // Remember the previous select to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= src_sel_i;
        else
            sel_q <= src_sel_i;
    end

    // A changed select drops any partial count from the old source.
    assign flush = (src_sel_i != sel_q);

    wdog_tick_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick_i),
        .instr_tick (instr_tick_i),
        .rtc_tick   (rtc_tick_i),
        .src        (src),
        .off        (wdt_off_i),
        .halt       (halt_i),
        .clr_req    (sw_clr_i),
        .adv        (adv),
        .clr        (clr)
    );

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .adv   (adv),
        .carry (carry)
    );

    wdog_stage #(.STG_W(STG_W)) u_stg (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .clr     (clr),
        .carry   (carry),
        .timeout (timeout_o)
    );

    // R4: time-out is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
    // R8: a select change never yields a time-out next cycle
    a_r8_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !timeout_o);
    // R5: disabled watchdog produces no time-out next cycle
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_off_i |=> !timeout_o);
endmodule

// File: tb/sel_clk_watchdog_test.sv
`timescale 1ns/1ps
module sel_clk_watchdog_test;
    localparam int PW   = 4;
    localparam int SW   = 1;
    localparam int FULL = 1 << (PW + SW);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic       instr_tick_i = 1'b0;
    logic       rtc_tick_i = 1'b0;
    logic [1:0] src_sel_i = 2'b00;
    logic       wdt_off_i = 1'b0;
    logic       sw_clr_i = 1'b0;
    logic       halt_i = 1'b0;
    logic       timeout_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sel_clk_watchdog #(.PRE_W(PW), .STG_W(SW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_tick_i   (osc_tick_i),
        .instr_tick_i (instr_tick_i),
        .rtc_tick_i   (rtc_tick_i),
        .src_sel_i    (src_sel_i),
        .wdt_off_i    (wdt_off_i),
        .sw_clr_i     (sw_clr_i),
        .halt_i       (halt_i),
        .timeout_o    (timeout_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample at the following negedge.
    // which: 0 osc, 1 instr, 2 rtc, 3 all, 4 none.
    task automatic cyc(input int which, input logic clr, output logic to);
        osc_tick_i   = (which == 0 || which == 3);
        instr_tick_i = (which == 1 || which == 3);
        rtc_tick_i   = (which == 2 || which == 3);
        sw_clr_i     = clr;
        @(negedge clk);
        to = timeout_o;
        osc_tick_i = 0; instr_tick_i = 0; rtc_tick_i = 0; sw_clr_i = 0;
    endtask

    // Give n ticks; check the index of the first time-out (0 = none).
    task automatic run_ticks(input int n, input int which, input int exp,
                             input string req);
        int first = 0;
        logic to;
        for (int i = 1; i <= n; i++) begin
            cyc(which, 1'b0, to);
            if (to && first == 0) first = i;
        end
        check(req, first, exp);
    endtask

    task automatic do_reset();
        logic to;
        rst_n = 0; halt_i = 0; wdt_off_i = 0;
        repeat (3) cyc(4, 1'b0, to);
        check("R1 reset output", int'(timeout_o), 0);
        rst_n = 1;
    endtask

    task automatic t_reset_full();
        logic to;
        do_reset();
        src_sel_i = 2'b00;
        run_ticks(FULL, 0, FULL, "R1 first window");
        cyc(4, 1'b0, to);
        check("R4 pulse one cycle", int'(to), 0);
        run_ticks(FULL + 4, 0, FULL, "R4 restart window");
    endtask

    task automatic t_clear_window();
        logic to;
        do_reset();
        run_ticks(15, 0, 0, "R3 pre-clear");
        cyc(4, 1'b1, to);
        check("R3 clear cycle", int'(to), 0);
        run_ticks(40, 0, FULL - 15, "R3 short window");
    endtask

    task automatic t_disable();
        logic to;
        do_reset();
        run_ticks(20, 0, 0, "R5 before off");
        wdt_off_i = 1;
        cyc(4, 1'b1, to);
        run_ticks(40, 0, 0, "R5 off no count");
        wdt_off_i = 0;
        run_ticks(40, 0, FULL - 20, "R5 clear ignored");
    endtask

    task automatic t_halt_instr();
        logic to;
        do_reset();
        src_sel_i = 2'b01;
        cyc(4, 1'b0, to);
        run_ticks(10, 1, 0, "R6 before halt");
        halt_i = 1;
        run_ticks(40, 1, 0, "R6 frozen");
        halt_i = 0;
        run_ticks(40, 1, FULL - 10, "R6 resume");
    endtask

    task automatic t_halt_other(input logic [1:0] s, input int which);
        logic to;
        do_reset();
        src_sel_i = s;
        cyc(4, 1'b0, to);
        halt_i = 1;
        run_ticks(40, which, FULL, "R7 halt ignored");
        halt_i = 0;
    endtask

    task automatic t_only_selected();
        logic to;
        do_reset();
        src_sel_i = 2'b10;
        cyc(4, 1'b0, to);
        run_ticks(40, 0, 0, "R2 osc ignored");
        run_ticks(40, 1, 0, "R2 instr ignored");
        run_ticks(40, 2, FULL, "R2 rtc counts");
    endtask

    task automatic t_sel_change();
        logic to;
        do_reset();
        src_sel_i = 2'b00;
        cyc(4, 1'b0, to);
        run_ticks(20, 0, 0, "R8 partial");
        src_sel_i = 2'b10;
        cyc(2, 1'b0, to);
        check("R8 change cycle", int'(to), 0);
        run_ticks(40, 2, FULL, "R8 flushed");
    endtask

    task automatic t_none();
        logic to;
        do_reset();
        src_sel_i = 2'b11;
        cyc(4, 1'b0, to);
        run_ticks(80, 3, 0, "R2 no source");
    endtask

    task automatic t_clr_collide();
        logic to;
        do_reset();
        src_sel_i = 2'b00;
        cyc(4, 1'b0, to);
        run_ticks(FULL - 1, 0, 0, "R9 lead-in");
        cyc(0, 1'b1, to);
        check("R9 clear beats final tick", int'(to), 0);
        run_ticks(40, 0, FULL, "R9 prescaler wrapped");
    endtask

    initial begin
        @(negedge clk);
        t_reset_full();
        t_clear_window();
        t_disable();
        t_halt_instr();
        t_halt_other(2'b00, 0);
        t_halt_other(2'b10, 2);
        t_only_selected();
        t_sel_change();
        t_none();
        t_clr_collide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule